// File: doc/BRIEF.md
# Multi-core partition clock and trace power controller

This block sits beside the processors of a multi-core microcontroller and decides, every cycle, which clock partitions may run. It raises enables for the shared bus fabric, for the DMA partition and for each core's local partition. It turns those enables into glitch-free gated clocks. It also passes through one clock that is never gated, so interrupt detection keeps working while every partition is stopped.

A second part handles power for the trace subsystem. Trace power is off after reset. A power request goes out as soon as any core turns its trace enable on, and a ready flag follows once the power switch acknowledges. The request then stays up while cores go to sleep, so trace buffers and trace settings survive. It is withdrawn only when every trace enable is low and software pulses a release input. After that, the block waits for the acknowledge to drop before trace power can be requested again.

Top module: `mc_clk_trace_ctrl`

## Requirements
- R1: `core_clk_en[i]` is high one cycle after `core_sleep[i]` is low or `dbg_attached` is high. It is low one cycle after `core_sleep[i]` is high while `dbg_attached` is low.
- R2: `bus_clk_en` is high one cycle after any core is awake (its `core_sleep` bit is 0), or `dbg_xfer` is high, or `dma_active` is high. Otherwise it is low.
- R3: `dma_clk_en` equals `dma_active` delayed by one cycle.
- R4: `free_clk` follows `clk` at all times, including during reset.
- R5: Each gated clock is high during a high phase of `clk` exactly when its enable was high after the preceding rising edge. Gated clocks therefore only produce whole pulses.
- R6: During reset all enables, all gated clocks, `trc_pwr_req` and `trc_ready` are low.
- R7: From the idle trace state, `trc_pwr_req` rises one cycle after any bit of `core_trc_en` is high.
- R8: While the request is up, it stays high in every cycle that follows a cycle with any trace enable high. This holds even when all cores are asleep.
- R9: A `trc_release` pulse has no effect while any trace enable is high or while trace power is idle.
- R10: With the request up and ready, `trc_release` high with all trace enables low drops `trc_pwr_req` and `trc_ready` on the next cycle. The block then stays powered down, ignoring trace enables, until `trc_pwr_ack` is seen low.
- R11: `trc_ready` rises one cycle after `trc_pwr_ack` is seen high while the request is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running source clock |
| rst_n | input | 1 | asynchronous active-low reset |
| core_sleep | input | NUM_CORES | per-core sleep status, 1 = asleep |
| dma_active | input | 1 | DMA controller has transfers in flight |
| dbg_attached | input | 1 | a debugger is connected |
| dbg_xfer | input | 1 | a debugger bus access is in progress |
| core_trc_en | input | NUM_CORES | per-core trace enable |
| trc_release | input | 1 | software pulse allowing trace power-down |
| trc_pwr_ack | input | 1 | trace power switch acknowledge |
| free_clk | output | 1 | ungated clock for interrupt detection |
| bus_gclk | output | 1 | gated clock of the shared bus partition |
| dma_gclk | output | 1 | gated clock of the DMA partition |
| core_gclk | output | NUM_CORES | gated clock of each core partition |
| bus_clk_en | output | 1 | registered enable of the shared bus partition |
| dma_clk_en | output | 1 | registered enable of the DMA partition |
| core_clk_en | output | NUM_CORES | registered enable of each core partition |
| trc_pwr_req | output | 1 | trace power-up request |
| trc_ready | output | 1 | trace power acknowledged and on |

## Verification
The enables and the trace request and ready flags are each one register behind their inputs. A result driven on a falling edge is therefore visible just after the next rising edge. The gated clocks lag one more edge, because the enable is captured during the low phase before they pulse. The driver applies inputs on falling edges and queues the expected enable and trace values. The monitor pops one item 1 ns after each rising edge, and compares the gated clocks at that instant against the previous item's enables.

// File: rtl/mctc_pkg.sv
package mctc_pkg;

   // Trace power sequencing states
   typedef enum logic [1:0] {
      TRC_OFF  = 2'd0,   // powered down, idle
      TRC_RISE = 2'd1,   // request up, waiting for acknowledge
      TRC_ON   = 2'd2,   // powered and ready
      TRC_FALL = 2'd3    // request withdrawn, waiting for acknowledge low
   } trc_state_e;

   localparam int MAX_CORES = 64;

endpackage

// File: rtl/mctc_gate_cell.sv
module mctc_gate_cell #(
   parameter bit LATCH_STYLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic gclk
);

   logic en_hold;

   generate
      if (LATCH_STYLE) begin : g_latch
         // transparent only while the source clock is low
         always_latch begin
            if (!rst_n)
               en_hold <= 1'b0;
            else if (!clk)
               en_hold <= en;
         end
      end else begin : g_negflop
         // enable sampled on the falling edge, stable through the high phase
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)
               en_hold <= 1'b0;
            else
               en_hold <= en;
         end
      end
   endgenerate

   assign gclk = clk & en_hold;

endmodule

// File: rtl/mctc_clk_enables.sv
module mctc_clk_enables #(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] core_sleep,
   input  logic                 dma_active,
   input  logic                 dbg_attached,
   input  logic                 dbg_xfer,
   output logic [NUM_CORES-1:0] core_en,
   output logic                 bus_en,
   output logic                 dma_en
);

   localparam int CW = NUM_CORES;

   logic [CW-1:0] awake;
   logic          past_valid;

   assign awake = ~core_sleep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_en    <= '0;
         bus_en     <= 1'b0;
         dma_en     <= 1'b0;
         past_valid <= 1'b0;
      end else begin
         core_en    <= awake | {CW{dbg_attached}};
         bus_en     <= (|awake) | dbg_xfer | dma_active;
         dma_en     <= dma_active;
         past_valid <= 1'b1;
      end
   end

   a_r1_debug_keeps_cores: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && $past(dbg_attached) |-> (&core_en));

   generate
      for (genvar i = 0; i < CW; i++) begin : g_core_chk
         a_r1_sleep_stops_core: assert property (@(posedge clk) disable iff (!rst_n)
            past_valid && $past(core_sleep[i] && !dbg_attached) |-> !core_en[i]);
      end
   endgenerate

   a_r2_bus_on_activity: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && $past((|awake) || dbg_xfer || dma_active) |-> bus_en);

   a_r2_bus_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && $past((&core_sleep) && !dbg_xfer && !dma_active) |-> !bus_en);

   a_r3_dma_follows: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid |-> dma_en == $past(dma_active));

endmodule

// File: rtl/mctc_trace_seq.sv
module mctc_trace_seq
   import mctc_pkg::*;
#(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] core_trc_en,
   input  logic                 trc_release,
   input  logic                 trc_pwr_ack,
   output logic                 trc_pwr_req,
   output logic                 trc_ready
);

   trc_state_e state_q, state_d;
   logic       any_trc;
   logic       past_valid;

   assign any_trc = |core_trc_en;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         TRC_OFF:  if (any_trc)                     state_d = TRC_RISE;
         TRC_RISE: if (trc_pwr_ack)                 state_d = TRC_ON;
         TRC_ON:   if (trc_release && !any_trc)     state_d = TRC_FALL;
         TRC_FALL: if (!trc_pwr_ack)                state_d = TRC_OFF;
         default:                                   state_d = TRC_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= TRC_OFF;
         past_valid <= 1'b0;
      end else begin
         state_q    <= state_d;
         past_valid <= 1'b1;
      end
   end

   assign trc_pwr_req = (state_q == TRC_RISE) || (state_q == TRC_ON);
   assign trc_ready   = (state_q == TRC_ON);

   a_r7_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && $rose(trc_pwr_req) |-> $past(any_trc));

   a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && $past(trc_pwr_req && any_trc) |-> trc_pwr_req);

   a_r10_drop_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && $fell(trc_pwr_req) |-> $past(trc_release && !any_trc));

   a_r11_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && $rose(trc_ready) |-> $past(trc_pwr_ack && trc_pwr_req));

endmodule

// File: rtl/mc_clk_trace_ctrl.sv
module mc_clk_trace_ctrl
   import mctc_pkg::*;
#(
   parameter int NUM_CORES   = 4,
   parameter bit LATCH_STYLE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] core_sleep,
   input  logic                 dma_active,
   input  logic                 dbg_attached,
   input  logic                 dbg_xfer,
   input  logic [NUM_CORES-1:0] core_trc_en,
   input  logic                 trc_release,
   input  logic                 trc_pwr_ack,
   output logic                 free_clk,
   output logic                 bus_gclk,
   output logic                 dma_gclk,
   output logic [NUM_CORES-1:0] core_gclk,
   output logic                 bus_clk_en,
   output logic                 dma_clk_en,
   output logic [NUM_CORES-1:0] core_clk_en,
   output logic                 trc_pwr_req,
   output logic                 trc_ready
);

   initial begin
      a_cfg_core_count: assert (NUM_CORES >= 1 && NUM_CORES <= MAX_CORES)
         else $error("NUM_CORES out of range");
   end

   // never gated: interrupt detection path
   assign free_clk = clk;

   mctc_clk_enables #(.NUM_CORES(NUM_CORES)) u_enables (
      .clk          (clk),
      .rst_n        (rst_n),
      .core_sleep   (core_sleep),
      .dma_active   (dma_active),
      .dbg_attached (dbg_attached),
      .dbg_xfer     (dbg_xfer),
      .core_en      (core_clk_en),
      .bus_en       (bus_clk_en),
      .dma_en       (dma_clk_en)
   );

   mctc_gate_cell #(.LATCH_STYLE(LATCH_STYLE)) u_bus_gate (
      .clk (clk), .rst_n (rst_n), .en (bus_clk_en), .gclk (bus_gclk)
   );

   mctc_gate_cell #(.LATCH_STYLE(LATCH_STYLE)) u_dma_gate (
      .clk (clk), .rst_n (rst_n), .en (dma_clk_en), .gclk (dma_gclk)
   );

   generate
      for (genvar i = 0; i < NUM_CORES; i++) begin : g_core_gate
         mctc_gate_cell #(.LATCH_STYLE(LATCH_STYLE)) u_gate (
            .clk (clk), .rst_n (rst_n), .en (core_clk_en[i]), .gclk (core_gclk[i])
         );
      end
   endgenerate

   mctc_trace_seq #(.NUM_CORES(NUM_CORES)) u_trace (
      .clk         (clk),
      .rst_n       (rst_n),
      .core_trc_en (core_trc_en),
      .trc_release (trc_release),
      .trc_pwr_ack (trc_pwr_ack),
      .trc_pwr_req (trc_pwr_req),
      .trc_ready   (trc_ready)
   );

   a_r6_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> !bus_clk_en && !dma_clk_en && core_clk_en == '0 && !trc_pwr_req && !trc_ready);

endmodule

// File: tb/mc_clk_trace_ctrl_test.sv
module mc_clk_trace_ctrl_test;

   localparam int N = 4;

   typedef struct {
      logic [N-1:0] core;
      logic         bus;
      logic         dma;
      logic         req;
      logic         rdy;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] core_sleep = '1;
   logic         dma_active = 1'b0;
   logic         dbg_attached = 1'b0;
   logic         dbg_xfer = 1'b0;
   logic [N-1:0] core_trc_en = '0;
   logic         trc_release = 1'b0;
   logic         trc_pwr_ack = 1'b0;
   logic         free_clk, bus_gclk, dma_gclk, bus_clk_en, dma_clk_en, trc_pwr_req, trc_ready;
   logic [N-1:0] core_gclk, core_clk_en;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   int   mst = 0;          // 0 idle, 1 requesting, 2 ready, 3 releasing
   exp_t q[$];

   always #2 clk = ~clk;   // 250 MHz

   mc_clk_trace_ctrl #(.NUM_CORES(N)) uut (
      .clk (clk), .rst_n (rst_n), .core_sleep (core_sleep), .dma_active (dma_active),
      .dbg_attached (dbg_attached), .dbg_xfer (dbg_xfer), .core_trc_en (core_trc_en),
      .trc_release (trc_release), .trc_pwr_ack (trc_pwr_ack), .free_clk (free_clk),
      .bus_gclk (bus_gclk), .dma_gclk (dma_gclk), .core_gclk (core_gclk),
      .bus_clk_en (bus_clk_en), .dma_clk_en (dma_clk_en), .core_clk_en (core_clk_en),
      .trc_pwr_req (trc_pwr_req), .trc_ready (trc_ready)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: apply inputs on a falling edge, queue the values due after the next rising edge
   task automatic step(input logic [N-1:0] slp, input logic dma, input logic conn, input logic xfer,
                       input logic [N-1:0] trc, input logic rel, input logic ack, input string tag);
      exp_t e;
      @(negedge clk);
      core_sleep = slp; dma_active = dma; dbg_attached = conn; dbg_xfer = xfer;
      core_trc_en = trc; trc_release = rel; trc_pwr_ack = ack;
      case (mst)
         0: if (|trc) mst = 1;
         1: if (ack) mst = 2;
         2: if (rel && !(|trc)) mst = 3;
         default: if (!ack) mst = 0;
      endcase
      e.core = ~slp | {N{conn}};
      e.bus  = (|(~slp)) | xfer | dma;
      e.dma  = dma;
      e.req  = (mst == 1) || (mst == 2);
      e.rdy  = (mst == 2);
      e.tag  = tag;
      q.push_back(e);
   endtask

   // monitor: compare 1 ns after each rising edge
   initial begin
      exp_t e;
      exp_t prev;
      prev.core = '0; prev.bus = 1'b0; prev.dma = 1'b0; prev.req = 1'b0; prev.rdy = 1'b0; prev.tag = "";
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            chk({"R1 core enable: ", e.tag}, 64'(core_clk_en), 64'(e.core));
            chk({"R2 bus enable: ", e.tag}, 64'(bus_clk_en), 64'(e.bus));
            chk({"R3 dma enable: ", e.tag}, 64'(dma_clk_en), 64'(e.dma));
            chk({"R7 R8 R10 trace request: ", e.tag}, 64'(trc_pwr_req), 64'(e.req));
            chk({"R11 trace ready: ", e.tag}, 64'(trc_ready), 64'(e.rdy));
            chk({"R5 core gated clocks: ", e.tag}, 64'(core_gclk), 64'(prev.core));
            chk({"R5 bus gated clock: ", e.tag}, 64'(bus_gclk), 64'(prev.bus));
            chk({"R5 dma gated clock: ", e.tag}, 64'(dma_gclk), 64'(prev.dma));
            chk({"R4 free clock high: ", e.tag}, 64'(free_clk), 64'd1);
            prev = e;
         end
      end
   end

   initial begin
      #20000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      core_sleep = '0;   // awake inputs during reset must not raise anything
      dma_active = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R6 reset enables", 64'({core_clk_en, bus_clk_en, dma_clk_en}), 64'd0);
      chk("R6 reset gated clocks", 64'({core_gclk, bus_gclk, dma_gclk}), 64'd0);
      chk("R6 reset trace", 64'({trc_pwr_req, trc_ready}), 64'd0);
      chk("R4 free clock in reset", 64'(free_clk), 64'd1);
      @(negedge clk);
      core_sleep = '1; dma_active = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      //   sleep    dma   conn  xfer  trace    rel   ack
      step(4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, "all asleep idle");
      step(4'b1110, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, "core0 awake");
      step(4'b0101, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b0, "cores 1,3 awake, R9 release while idle");
      step(4'b1111, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, "dma only");
      step(4'b1111, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, "debug access only");
      step(4'b1111, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, "debugger attached, all asleep");
      step(4'b1011, 1'b1, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, "debugger plus core2 and dma");
      step(4'b1111, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b0, "R7 core1 trace on");
      step(4'b1111, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b0, "R8 waiting ack");
      step(4'b1111, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b1, "R11 ack arrives");
      step(4'b1111, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b1, 1'b1, "R9 release ignored while trace on");
      step(4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, "R8 asleep trace kept");
      step(4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1, "R10 release");
      step(4'b1111, 1'b0, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b1, "R10 enable during release ignored");
      step(4'b1111, 1'b0, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b0, "R10 ack low ends release");
      step(4'b0000, 1'b0, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b0, "R7 request again, cores awake");
      step(4'b0000, 1'b0, 1'b0, 1'b0, 4'b1001, 1'b0, 1'b1, "R11 second ack");
      step(4'b1111, 1'b1, 1'b0, 1'b0, 4'b0001, 1'b1, 1'b1, "R9 release with core0 trace");
      step(4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1, "R10 second release");
      step(4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, "R10 back to idle");
      step(4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, "idle settle");
      repeat (3) @(posedge clk);
      #1;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule